// File: doc/BRIEF.md
# Display Page Memory Register Interface

This block sits between a byte-wide host port and the character memory of a teletext-style decoder. The host opens a transfer by loading a register index, then moves bytes one at a time. After each byte the index steps to the next register, so one burst can program every control register in turn and then reach the data register. Eight control bytes drive the decoder's modes. Three pointer registers select a chapter, a row and a column. The data register reads or writes the character byte at that location, and the column then moves on by itself, so a whole page can be streamed without setting the pointers again.

When reset is released, a sequencer writes one memory byte per clock until the whole memory holds the space code. The single exception is column 7 of row 0 in chapter 0, which receives the white-text attribute code. While the fill runs, the block raises `busy` and ignores the host port. A read-only status register holds a flag that sets when the row pointer wraps at the end of a page. Reading the status register clears the flag.

Top module: `page_mem_regif`

## Requirements
- R1: After reset, every control byte and every pointer is 00h, except control bytes 5 and 6, which are 03h. The register index is 0 and the page-wrap flag is 0.
- R2: After reset, `busy` stays high for exactly CHAPTERS*ROWS*COLS cycles. During that time each memory byte is set to 20h, except chapter 0, row 0, column 7, which is set to 07h.
- R3: While `busy` is high, all host strobes are ignored.
- R4: A cycle with `sel_vld` high loads the register index from `sel_idx` and performs no access. Index values: 0 to 7 are control bytes, 8 is chapter, 9 is row, 10 is column, 11 is data, 12 is status, and 13 to 15 are empty. If `wr_vld` and `rd_vld` are both high, the cycle is a write. After each write or read, an index below 11 goes up by one, and an index of 11 or more stays where it is.
- R5: A write to index 0 to 7 sets that control byte. Control byte k appears on `ctrl_regs[8k+7:8k]`. Writes to indexes 8, 9 and 10 set `chap_ptr`, `row_ptr` and `col_ptr`.
- R6: A read returns its byte on `rd_byte` one cycle later, with `rd_valid` high for that one cycle. Reads of indexes 0 to 10 and 13 to 15 return 00h.
- R7: A data access reads or writes the memory byte at (chap_ptr, row_ptr, col_ptr).
- R8: After each in-range data access, the column goes up by one. Column COLS-1 goes to 0, and the row then goes up by one. Row ROWS-1 goes to 0 and sets the page-wrap flag. The chapter pointer does not change.
- R9: A status read returns 00h with the page-wrap flag in bit 0, and it clears the flag.
- R10: A write to the status index changes no control byte, pointer, flag or memory byte.
- R11: If any pointer is out of range, a data access writes nothing, reads 00h and leaves the pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_vld | input | 1 | Load the register index |
| sel_idx | input | 4 | Register index to load |
| wr_vld | input | 1 | Write strobe |
| wr_byte | input | 8 | Write data |
| rd_vld | input | 1 | Read strobe |
| rd_byte | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |
| busy | output | 1 | Memory fill in progress |
| ctrl_regs | output | 64 | Control bytes 0 to 7, packed |
| chap_ptr | output | 8 | Chapter pointer |
| row_ptr | output | 8 | Row pointer |
| col_ptr | output | 8 | Column pointer |

## Verification
The bench builds the block with 2 chapters of 3 rows by 10 columns. With this size the fill finishes in 60 cycles, and a read sweep over a whole chapter is short. Both the column wrap and the row wrap that sets the flag are therefore reached within a few dozen accesses. The marked byte at column 7 still falls inside a row, so the one exception to the fill is covered. The chapter count of 2 leaves chapter values 2 and up, and column values 10 and up, to exercise the out-of-range path.

// File: rtl/page_mem_regif.sv
module page_mem_regif #(
  parameter int CHAPTERS = 2,
  parameter int ROWS     = 26,
  parameter int COLS     = 40,
  parameter logic [7:0] FILL = 8'h20,
  parameter logic [7:0] MARK = 8'h07,
  parameter int MARK_COL = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_vld,
  input  logic [3:0]  sel_idx,
  input  logic        wr_vld,
  input  logic [7:0]  wr_byte,
  input  logic        rd_vld,
  output logic [7:0]  rd_byte,
  output logic        rd_valid,
  output logic        busy,
  output logic [63:0] ctrl_regs,
  output logic [7:0]  chap_ptr,
  output logic [7:0]  row_ptr,
  output logic [7:0]  col_ptr
);
  localparam int DEPTH = CHAPTERS * ROWS * COLS;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [3:0] IDX_DATA = 4'd11;
  localparam logic [3:0] IDX_STAT = 4'd12;

  logic [7:0]    mem [DEPTH];
  logic [7:0]    ctrl [8];
  logic [AW-1:0] init_cnt;
  logic [3:0]    reg_ptr;
  logic          wrap_flag;

  wire acc     = !busy && !sel_vld && (wr_vld || rd_vld);
  wire in_rng  = (chap_ptr < 8'(CHAPTERS)) && (row_ptr < 8'(ROWS)) && (col_ptr < 8'(COLS));
  wire data_ok = acc && (reg_ptr == IDX_DATA) && in_rng;
  wire end_col = col_ptr == 8'(COLS - 1);
  wire end_row = row_ptr == 8'(ROWS - 1);
  wire [AW-1:0] flat = AW'((32'(chap_ptr) * ROWS + 32'(row_ptr)) * COLS + 32'(col_ptr));

  for (genvar k = 0; k < 8; k++) begin : g_pack
    assign ctrl_regs[8*k +: 8] = ctrl[k];
  end

  always_ff @(posedge clk) begin
    if (busy) mem[init_cnt] <= (init_cnt == AW'(MARK_COL)) ? MARK : FILL;
    else if (data_ok && wr_vld) mem[flat] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_byte  <= 8'h00;
    end else begin
      rd_valid <= acc && !wr_vld;
      if (acc && !wr_vld) begin
        if (reg_ptr == IDX_DATA) rd_byte <= in_rng ? mem[flat] : 8'h00;
        else if (reg_ptr == IDX_STAT) rd_byte <= {7'd0, wrap_flag};
        else rd_byte <= 8'h00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b1;
      init_cnt  <= '0;
      reg_ptr   <= 4'd0;
      wrap_flag <= 1'b0;
      chap_ptr  <= 8'h00;
      row_ptr   <= 8'h00;
      col_ptr   <= 8'h00;
      for (int k = 0; k < 8; k++) ctrl[k] <= (k == 5 || k == 6) ? 8'h03 : 8'h00;
    end else if (busy) begin
      init_cnt <= init_cnt + 1'b1;
      if (init_cnt == AW'(DEPTH - 1)) busy <= 1'b0;
    end else if (sel_vld) begin
      reg_ptr <= sel_idx;
    end else if (acc) begin
      if (reg_ptr < IDX_DATA) reg_ptr <= reg_ptr + 4'd1;
      if (wr_vld) begin
        if (reg_ptr < 4'd8) ctrl[reg_ptr[2:0]] <= wr_byte;
        else if (reg_ptr == 4'd8) chap_ptr <= wr_byte;
        else if (reg_ptr == 4'd9) row_ptr <= wr_byte;
        else if (reg_ptr == 4'd10) col_ptr <= wr_byte;
      end else if (reg_ptr == IDX_STAT) begin
        wrap_flag <= 1'b0;
      end
      if (data_ok) begin
        if (end_col) begin
          col_ptr <= 8'h00;
          if (end_row) begin
            row_ptr   <= 8'h00;
            wrap_flag <= 1'b1;
          end else begin
            row_ptr <= row_ptr + 8'd1;
          end
        end else begin
          col_ptr <= col_ptr + 8'd1;
        end
      end
    end
  end
endmodule

module page_mem_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        sel_vld,
  input logic        wr_vld,
  input logic        rd_vld,
  input logic [3:0]  reg_ptr,
  input logic        rd_valid,
  input logic [63:0] ctrl_regs,
  input logic [7:0]  chap_ptr,
  input logic [7:0]  row_ptr,
  input logic [7:0]  col_ptr
);
  // R2
  fill_once_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> !busy);
  // R3
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl_regs) && $stable({chap_ptr, row_ptr, col_ptr}));
  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sel_vld && (wr_vld || rd_vld) && reg_ptr >= 4'd11) |=> $stable(reg_ptr));
  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_vld && !wr_vld && !sel_vld && !busy));
  // R8
  chap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sel_vld && rd_vld && reg_ptr == 4'd11) |=> $stable(chap_ptr));
  // R10
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sel_vld && wr_vld && reg_ptr == 4'd12) |=>
      $stable(ctrl_regs) && $stable({chap_ptr, row_ptr, col_ptr}));
endmodule

bind page_mem_regif page_mem_regif_chk chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sel_vld(sel_vld), .wr_vld(wr_vld),
  .rd_vld(rd_vld), .reg_ptr(reg_ptr), .rd_valid(rd_valid), .ctrl_regs(ctrl_regs),
  .chap_ptr(chap_ptr), .row_ptr(row_ptr), .col_ptr(col_ptr)
);

// File: tb/page_mem_regif_test.sv
`timescale 1ns/1ps
module page_mem_regif_test;
  localparam int NC = 2, NR = 3, NK = 10, DEPTH = NC * NR * NK;

  logic clk = 0, rst_n = 0, sel_vld = 0, wr_vld = 0, rd_vld = 0;
  logic [3:0] sel_idx = 0;
  logic [7:0] wr_byte = 0;
  logic [7:0] rd_byte, chap_ptr, row_ptr, col_ptr;
  logic rd_valid, busy;
  logic [63:0] ctrl_regs;

  page_mem_regif #(.CHAPTERS(NC), .ROWS(NR), .COLS(NK)) uut (
    .clk(clk), .rst_n(rst_n), .sel_vld(sel_vld), .sel_idx(sel_idx), .wr_vld(wr_vld),
    .wr_byte(wr_byte), .rd_vld(rd_vld), .rd_byte(rd_byte), .rd_valid(rd_valid),
    .busy(busy), .ctrl_regs(ctrl_regs), .chap_ptr(chap_ptr), .row_ptr(row_ptr), .col_ptr(col_ptr));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  int m_mem [DEPTH];
  logic [63:0] m_ctrl;
  int m_ptr, m_ch, m_rw, m_cl, m_cnt, m_flag;
  bit m_busy, m_rv;
  int m_rb;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 64'h0003_0300_0000_0000;
      m_ptr = 0; m_ch = 0; m_rw = 0; m_cl = 0; m_cnt = 0; m_flag = 0;
      m_busy = 1; m_rv = 0; m_rb = 0;
    end else if (m_busy) begin
      m_mem[m_cnt] = (m_cnt == 7) ? 8'h07 : 8'h20;
      m_cnt++;
      if (m_cnt == DEPTH) m_busy = 0;
      m_rv = 0;
    end else if (sel_vld) begin
      m_ptr = sel_idx;
      m_rv = 0;
    end else if (wr_vld || rd_vld) begin
      automatic bit inr = m_ch < NC && m_rw < NR && m_cl < NK;
      automatic int a = (m_ch * NR + m_rw) * NK + m_cl;
      automatic int p = m_ptr;
      m_rv = !wr_vld;
      if (!wr_vld) m_rb = (p == 11) ? (inr ? m_mem[a] : 0) : (p == 12) ? m_flag : 0;
      if (p < 11) m_ptr = p + 1;
      if (wr_vld) begin
        if (p < 8) m_ctrl[8*p +: 8] = wr_byte;
        else if (p == 8) m_ch = wr_byte;
        else if (p == 9) m_rw = wr_byte;
        else if (p == 10) m_cl = wr_byte;
        else if (p == 11 && inr) m_mem[a] = wr_byte;
      end else if (p == 12) m_flag = 0;
      if (p == 11 && inr) begin
        m_cl++;
        if (m_cl == NK) begin
          m_cl = 0; m_rw++;
          if (m_rw == NR) begin m_rw = 0; m_flag = 1; end
        end
      end
    end else m_rv = 0;
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(busy == m_busy, {phase, "/R2 busy"}, busy, m_busy);
      check(rd_valid == m_rv, {phase, "/R6 rd_valid"}, rd_valid, m_rv);
      if (m_rv) check(rd_byte == 8'(m_rb), {phase, "/R7 rd_byte"}, rd_byte, m_rb);
      check(ctrl_regs == m_ctrl, {phase, "/R5 ctrl"}, ctrl_regs, m_ctrl);
      check(chap_ptr == 8'(m_ch), {phase, "/R8 chap"}, chap_ptr, m_ch);
      check(row_ptr == 8'(m_rw), {phase, "/R8 row"}, row_ptr, m_rw);
      check(col_ptr == 8'(m_cl), {phase, "/R8 col"}, col_ptr, m_cl);
    end
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(bit s, int i, bit w, int b, bit r);
    @(negedge clk);
    sel_vld = s; sel_idx = 4'(i); wr_vld = w; wr_byte = 8'(b); rd_vld = r;
  endtask
  task automatic sel(int i);  step(1, i, 0, 0, 0); endtask
  task automatic wr(int b);   step(0, 0, 1, b, 0); endtask
  task automatic rd();        step(0, 0, 0, 0, 1); endtask
  task automatic idle(int n); repeat (n) step(0, 0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    check(ctrl_regs == 64'h0003_0300_0000_0000, "R1 reset ctrl", ctrl_regs, 64'h0003_0300_0000_0000);
    check(busy == 1, "R2 busy after reset", busy, 1);
    phase = "R3";
    sel(8); wr(1); wr(2); rd();
    idle(DEPTH);
    phase = "R2";
    check(busy == 0, "R2 fill finished", busy, 0);
    sel(8); wr(0); wr(0); wr(0);
    for (int k = 0; k < NR * NK + 2; k++) rd();
    phase = "R9";
    sel(12); rd(); rd();
    phase = "R5";
    sel(0);
    for (int k = 0; k < 8; k++) wr(8'h11 * (k + 1));
    wr(1); wr(2); wr(8);
    phase = "R8";
    for (int k = 0; k < 5; k++) wr(8'hA0 + k);
    phase = "R9";
    sel(12); rd();
    phase = "R7";
    sel(8); wr(1); wr(2); wr(8);
    for (int k = 0; k < 6; k++) rd();
    phase = "R6";
    sel(3); rd(); rd(); sel(13); rd();
    phase = "R10";
    sel(12); wr(8'hFF); wr(8'h01); rd();
    phase = "R11";
    sel(10); wr(50); wr(8'h55); rd();
    sel(8); wr(5); wr(0); wr(0); wr(8'h66); rd();
    phase = "R4";
    sel(8); wr(0); wr(0); wr(0);
    step(1, 2, 1, 8'h77, 1);
    wr(8'h42);
    step(0, 0, 1, 8'h43, 1);
    sel(11); rd(); rd();
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule